// File: doc/BRIEF.md
# Dual-Channel Registered Bus Transceiver

This block moves data between an A-side bus and a B-side bus, one byte-wide lane per channel, with a default of two channels that run fully independently. Each lane holds two capture registers. One latches the A-side input on a rising edge of its own A-capture clock. The other latches the B-side input on a rising edge of its own B-capture clock. These captures happen in every control state, including while the lane is isolated.

An active-low output enable and a direction bit set which side, if any, the lane drives. Two source selects choose, for each direction, between the live value arriving from the far bus and the value held in that bus's capture register. The live path has no register in it. Tri-state buses are modelled as separate input, output and output-enable signals. An undriven output reads as zero.

Top module: `dual_reg_xcvr`

## Requirements
- R1: The block has N_CH lanes of W bits each (default 2 x 8), and lane i uses only bits [i*W +: W] of each data vector and bit i of each control vector, so activity on one lane leaves every other lane's outputs unchanged.
- R2: A rising edge on cap_a_clk[i] stores lane i of a_in in its A register, and a rising edge on cap_b_clk[i] stores lane i of b_in in its B register. Both captures happen regardless of oe_n and dir, and a register holds its value between its clock edges.
- R3: While oe_n[i] is 1 (isolation), both a_oe[i] and b_oe[i] are 0, and captures still take place.
- R4: With oe_n[i]=0 and dir[i]=0, a_oe[i]=1 and b_oe[i]=0. The A output carries lane i of b_in combinationally when sel_b2a[i]=0, and the B register contents when sel_b2a[i]=1.
- R5: With oe_n[i]=0 and dir[i]=1, b_oe[i]=1 and a_oe[i]=0. The B output carries lane i of a_in combinationally when sel_a2b[i]=0, and the A register contents when sel_a2b[i]=1.
- R6: a_oe[i] and b_oe[i] are never 1 at the same time.
- R7: rst_n=0 clears both registers of every lane to zero at once, without waiting for a clock.
- R8: A lane's output data vector reads zero whenever its output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous clear of all capture registers, active low |
| oe_n | input | N_CH | Per-lane output enable, active low |
| dir | input | N_CH | Per-lane direction: 0 drives A, 1 drives B |
| cap_a_clk | input | N_CH | Per-lane capture clock for the A register |
| cap_b_clk | input | N_CH | Per-lane capture clock for the B register |
| sel_a2b | input | N_CH | Source for B output: 0 live A, 1 stored A |
| sel_b2a | input | N_CH | Source for A output: 0 live B, 1 stored B |
| a_in | input | N_CH*W | A-side bus input |
| b_in | input | N_CH*W | B-side bus input |
| a_out | output | N_CH*W | A-side bus drive value |
| b_out | output | N_CH*W | B-side bus drive value |
| a_oe | output | N_CH | Per-lane A-side output enable |
| b_oe | output | N_CH | Per-lane B-side output enable |

## Verification
The properties are sampled on each lane's capture-clock edges. They take for granted that controls and bus inputs are steady around those edges, so the value seen at an edge is the value that was stored. The stored-path check compares against the input seen at the previous edge of the same clock. It therefore assumes that no reset fell in between, and a flag cleared by reset enforces that. The bench changes every input on the falling half of its time-base clock and raises capture clocks only after a settling delay, which keeps inputs steady at every capture edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic [1:0] {
      XM_ISOLATE = 2'd0,
      XM_DRIVE_A = 2'd1,
      XM_DRIVE_B = 2'd2
   } xcvr_mode_e;

   function automatic xcvr_mode_e xcvr_decode(input logic en_n, input logic to_b);
      if (en_n)
         return XM_ISOLATE;
      else if (to_b)
         return XM_DRIVE_B;
      else
         return XM_DRIVE_A;
   endfunction

endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_VAL;
      else
         q <= d;
   end

endmodule

// File: rtl/xcvr_out_sel.sv
module xcvr_out_sel #(
   parameter int unsigned W = 8,
   parameter bit GATE_IDLE = 1'b1
) (
   input  logic [W-1:0] live,
   input  logic [W-1:0] stored,
   input  logic         use_stored,
   input  logic         drive,
   output logic [W-1:0] q
);

   logic [W-1:0] picked;

   assign picked = use_stored ? stored : live;

   generate
      if (GATE_IDLE) begin : g_gated
         assign q = drive ? picked : '0;
      end else begin : g_open
         logic unused_drive;
         assign unused_drive = drive;
         assign q = picked;
      end
   endgenerate

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int unsigned W = 8,
   parameter bit GATE_IDLE = 1'b1
) (
   input  logic         rst_n,
   input  logic         oe_n,
   input  logic         dir,
   input  logic         clk_a,
   input  logic         clk_b,
   input  logic         sel_a2b,
   input  logic         sel_b2a,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] b_out,
   output logic         a_oe,
   output logic         b_oe
);

   logic [W-1:0] held_a;
   logic [W-1:0] held_b;
   xcvr_mode_e   mode;

   assign mode = xcvr_decode(oe_n, dir);
   assign a_oe = (mode == XM_DRIVE_A);
   assign b_oe = (mode == XM_DRIVE_B);

   xcvr_hold_reg #(.W(W)) u_reg_a (
      .clk(clk_a), .rst_n(rst_n), .d(a_in), .q(held_a)
   );

   xcvr_hold_reg #(.W(W)) u_reg_b (
      .clk(clk_b), .rst_n(rst_n), .d(b_in), .q(held_b)
   );

   xcvr_out_sel #(.W(W), .GATE_IDLE(GATE_IDLE)) u_to_a (
      .live(b_in), .stored(held_b), .use_stored(sel_b2a),
      .drive(a_oe), .q(a_out)
   );

   xcvr_out_sel #(.W(W), .GATE_IDLE(GATE_IDLE)) u_to_b (
      .live(a_in), .stored(held_a), .use_stored(sel_a2b),
      .drive(b_oe), .q(b_out)
   );

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
   parameter int unsigned N_CH = 2,
   parameter int unsigned W = 8,
   parameter bit GATE_IDLE = 1'b1
) (
   input  logic                rst_n,
   input  logic [N_CH-1:0]     oe_n,
   input  logic [N_CH-1:0]     dir,
   input  logic [N_CH-1:0]     cap_a_clk,
   input  logic [N_CH-1:0]     cap_b_clk,
   input  logic [N_CH-1:0]     sel_a2b,
   input  logic [N_CH-1:0]     sel_b2a,
   input  logic [N_CH*W-1:0]   a_in,
   input  logic [N_CH*W-1:0]   b_in,
   output logic [N_CH*W-1:0]   a_out,
   output logic [N_CH*W-1:0]   b_out,
   output logic [N_CH-1:0]     a_oe,
   output logic [N_CH-1:0]     b_oe
);

   localparam int unsigned BUS_W = N_CH * W;

   if (N_CH < 1) begin : g_bad_nch
      $error("dual_reg_xcvr: N_CH must be at least 1");
   end
   if (W < 1) begin : g_bad_w
      $error("dual_reg_xcvr: W must be at least 1");
   end
   if (BUS_W > 4096) begin : g_bad_bus
      $error("dual_reg_xcvr: total bus width too large");
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_lane
      xcvr_lane #(.W(W), .GATE_IDLE(GATE_IDLE)) u_lane (
         .rst_n   (rst_n),
         .oe_n    (oe_n[g]),
         .dir     (dir[g]),
         .clk_a   (cap_a_clk[g]),
         .clk_b   (cap_b_clk[g]),
         .sel_a2b (sel_a2b[g]),
         .sel_b2a (sel_b2a[g]),
         .a_in    (a_in[g*W +: W]),
         .b_in    (b_in[g*W +: W]),
         .a_out   (a_out[g*W +: W]),
         .b_out   (b_out[g*W +: W]),
         .a_oe    (a_oe[g]),
         .b_oe    (b_oe[g])
      );
   end

endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
   parameter int unsigned N_CH = 2,
   parameter int unsigned W = 8
) (
   input logic              rst_n,
   input logic [N_CH-1:0]   oe_n,
   input logic [N_CH-1:0]   cap_a_clk,
   input logic [N_CH-1:0]   cap_b_clk,
   input logic [N_CH-1:0]   sel_a2b,
   input logic [N_CH-1:0]   sel_b2a,
   input logic [N_CH*W-1:0] a_in,
   input logic [N_CH*W-1:0] b_in,
   input logic [N_CH*W-1:0] a_out,
   input logic [N_CH*W-1:0] b_out,
   input logic [N_CH-1:0]   a_oe,
   input logic [N_CH-1:0]   b_oe
);

   for (genvar g = 0; g < N_CH; g++) begin : g_chk
      logic seen_a;
      logic seen_b;

      always_ff @(posedge cap_a_clk[g] or negedge rst_n) begin
         if (!rst_n) seen_a <= 1'b0;
         else        seen_a <= 1'b1;
      end

      always_ff @(posedge cap_b_clk[g] or negedge rst_n) begin
         if (!rst_n) seen_b <= 1'b0;
         else        seen_b <= 1'b1;
      end

      p_oe_excl_r6: assert property (@(posedge cap_a_clk[g]) disable iff (!rst_n)
         !(a_oe[g] && b_oe[g]));

      p_isolate_r3: assert property (@(posedge cap_b_clk[g]) disable iff (!rst_n)
         oe_n[g] |-> (!a_oe[g] && !b_oe[g]));

      p_live_a2b_r5: assert property (@(posedge cap_a_clk[g]) disable iff (!rst_n)
         (b_oe[g] && !sel_a2b[g]) |-> (b_out[g*W +: W] == a_in[g*W +: W]));

      p_live_b2a_r4: assert property (@(posedge cap_b_clk[g]) disable iff (!rst_n)
         (a_oe[g] && !sel_b2a[g]) |-> (a_out[g*W +: W] == b_in[g*W +: W]));

      p_store_a2b_r2: assert property (@(posedge cap_a_clk[g]) disable iff (!rst_n)
         (seen_a && b_oe[g] && sel_a2b[g]) |-> (b_out[g*W +: W] == $past(a_in[g*W +: W])));

      p_store_b2a_r2: assert property (@(posedge cap_b_clk[g]) disable iff (!rst_n)
         (seen_b && a_oe[g] && sel_b2a[g]) |-> (a_out[g*W +: W] == $past(b_in[g*W +: W])));

      p_idle_zero_r8: assert property (@(posedge cap_a_clk[g]) disable iff (!rst_n)
         !b_oe[g] |-> (b_out[g*W +: W] == '0));
   end

endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.N_CH(N_CH), .W(W)) u_chk (
   .rst_n(rst_n), .oe_n(oe_n), .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk),
   .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .a_in(a_in), .b_in(b_in),
   .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe)
);

// File: tb/tb_dual_reg_xcvr.sv
`timescale 1ns/1ps
module tb_dual_reg_xcvr;

   localparam int N_CH = 2;
   localparam int W = 8;

   typedef struct packed {
      logic       oe_n;
      logic       dir;
      logic       sab;
      logic       sba;
      logic [7:0] a;
      logic [7:0] b;
      logic       pa;
      logic       pb;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b1, 1'b1},
      '{1'b1, 1'b1, 1'b1, 1'b1, 8'h11, 8'h22, 1'b1, 1'b0},
      '{1'b0, 1'b1, 1'b1, 1'b0, 8'h77, 8'h88, 1'b0, 1'b0},
      '{1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, 8'h00, 1'b0, 1'b0},
      '{1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h99, 1'b0, 1'b0},
      '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3, 1'b0, 1'b0},
      '{1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hE7, 1'b0, 1'b1},
      '{1'b0, 1'b1, 1'b1, 1'b0, 8'hF0, 8'h00, 1'b1, 1'b0},
      '{1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0},
      '{1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n;
   logic [N_CH-1:0]   oe_n, dir, cap_a_clk, cap_b_clk, sel_a2b, sel_b2a;
   logic [N_CH*W-1:0] a_in, b_in, a_out, b_out;
   logic [N_CH-1:0]   a_oe, b_oe;

   dual_reg_xcvr #(.N_CH(N_CH), .W(W)) dut (
      .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .cap_a_clk(cap_a_clk),
      .cap_b_clk(cap_b_clk), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
      .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
      .a_oe(a_oe), .b_oe(b_oe)
   );

   int total = 0;
   int bad = 0;
   logic [7:0] ra [N_CH];
   logic [7:0] rb [N_CH];

   task automatic check(input int ch, input string req);
      logic eao, ebo;
      logic [7:0] ea, eb;
      logic [17:0] act, exp;
      eao = !oe_n[ch] && !dir[ch];
      ebo = !oe_n[ch] && dir[ch];
      ea = eao ? (sel_b2a[ch] ? rb[ch] : b_in[ch*W +: W]) : 8'h00;
      eb = ebo ? (sel_a2b[ch] ? ra[ch] : a_in[ch*W +: W]) : 8'h00;
      exp = {eao, ebo, ea, eb};
      act = {a_oe[ch], b_oe[ch], a_out[ch*W +: W], b_out[ch*W +: W]};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s lane %0d: got %h expected %h", req, ch, act, exp);
      end
   endtask

   task automatic apply(input int ch, input vec_t v);
      oe_n[ch] = v.oe_n;
      dir[ch] = v.dir;
      sel_a2b[ch] = v.sab;
      sel_b2a[ch] = v.sba;
      a_in[ch*W +: W] = v.a;
      b_in[ch*W +: W] = v.b;
   endtask

   task automatic pulse(input vec_t v0, input vec_t v1);
      #1;
      cap_a_clk = {v1.pa, v0.pa};
      cap_b_clk = {v1.pb, v0.pb};
      if (v0.pa) ra[0] = v0.a;
      if (v0.pb) rb[0] = v0.b;
      if (v1.pa) ra[1] = v1.a;
      if (v1.pb) rb[1] = v1.b;
      #1;
      cap_a_clk = '0;
      cap_b_clk = '0;
   endtask

   initial begin
      #1_000_000;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      oe_n = '1; dir = '0; cap_a_clk = '0; cap_b_clk = '0;
      sel_a2b = '0; sel_b2a = '0; a_in = '0; b_in = '0;
      for (int c = 0; c < N_CH; c++) begin ra[c] = 8'h00; rb[c] = 8'h00; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R3: reset state, isolated, nothing driven
      check(0, "R3");
      rst_n = 1'b1;
      // R7: registers read zero after reset through the stored paths
      oe_n = 2'b00; dir = 2'b01; sel_a2b = '1; sel_b2a = '1;
      a_in = 16'hFFFF; b_in = 16'hFFFF;
      #3;
      check(0, "R7");
      check(1, "R7");

      // table walk; lane 1 gets a varied copy so lanes differ (R1)
      for (int i = 0; i < NV; i++) begin
         vec_t v1;
         @(negedge clk);
         v1 = VEC[i];
         v1.dir = ~VEC[i].dir;
         v1.sab = VEC[i].sba;
         v1.sba = VEC[i].sab;
         v1.a = VEC[i].a ^ 8'h0F;
         v1.b = VEC[i].b ^ 8'hF0;
         v1.pa = VEC[i].pb;
         v1.pb = VEC[i].pa;
         apply(0, VEC[i]);
         apply(1, v1);
         pulse(VEC[i], v1);
         #1;
         check(0, "R2 R4 R5 R6 R8");
         check(1, "R1 R3");
      end

      // R2: captures made in isolation surface later on the stored path
      @(negedge clk);
      begin
         vec_t v0, v1;
         v0 = '{1'b1, 1'b0, 1'b0, 1'b0, 8'h6B, 8'h4D, 1'b1, 1'b1};
         v1 = '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0};
         apply(0, v0); apply(1, v1);
         pulse(v0, v1);
         #1;
         check(0, "R3");
         oe_n[0] = 1'b0; dir[0] = 1'b1; sel_a2b[0] = 1'b1; a_in[7:0] = 8'h00;
         #1;
         check(0, "R2");
         dir[0] = 1'b0; sel_b2a[0] = 1'b1; b_in[7:0] = 8'h00;
         #1;
         check(0, "R2");
      end

      // R1: pulsing lane 0 only leaves lane 1 unchanged
      @(negedge clk);
      oe_n[1] = 1'b0; dir[1] = 1'b1; sel_a2b[1] = 1'b1;
      begin
         vec_t v0, v1;
         v0 = '{1'b0, 1'b1, 1'b1, 1'b0, 8'h3E, 8'h00, 1'b1, 1'b0};
         v1 = '{1'b0, 1'b1, 1'b1, 1'b0, 8'hC1, 8'h00, 1'b0, 1'b0};
         apply(0, v0); apply(1, v1);
         pulse(v0, v1);
         #1;
         check(1, "R1");
         check(0, "R1");
      end

      // R7: asynchronous clear mid-run, no clock
      @(negedge clk);
      rst_n = 1'b0;
      for (int c = 0; c < N_CH; c++) begin ra[c] = 8'h00; rb[c] = 8'h00; end
      #1;
      oe_n = 2'b00; dir = 2'b10; sel_a2b = '1; sel_b2a = '1;
      #1;
      check(0, "R7");
      check(1, "R7");
      rst_n = 1'b1;

      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule